// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block gives the fetch stage its next program counter in the same cycle the fetch address is presented, before the instruction is decoded. It is a direct-mapped table of 2^IDX_W entries. Each entry holds a valid flag, the complete address of a control instruction, that instruction's last known target, and one direction bit. A lookup that matches the whole address and finds the direction bit set steers fetch to the stored target. Every other case, including an address that shares an index with a different instruction, falls through to the sequential address (PC+4).

When a control instruction resolves in the execute stage, the pipeline sends its address, its real outcome and target, and the next PC that fetch actually used after it. The block raises a kill in that same cycle if the two disagree, and chooses one of five update actions. `ACT_IDLE`: no control instruction resolves. `ACT_SKIP`: not-taken instruction with no entry. `ACT_ALLOC`: taken instruction with no entry takes over its index. `ACT_FIX`: matching entry that mispredicted gets its direction and, when taken, its target rewritten. `ACT_TRAIN`: matching entry that predicted right has only its direction bit refreshed. The table writes on the clock edge that ends the resolution cycle. Lookups see the new contents from the next cycle on.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports no hit and a next PC of fetch_pc+4.
- R2: A lookup hits only when the indexed entry is valid and its stored address equals all PC_W bits of fetch_pc. A different address at the same index misses and gets fetch_pc+4.
- R3: On a hit whose direction bit is 1 (taken), the next PC is the stored target. On a hit whose direction bit is 0, the next PC is fetch_pc+4.
- R4: The index is fetch_pc[IDX_W+1:2]. It is output on lk_index, and the same bits of res_pc select the entry at resolution.
- R5: A resolved taken control instruction without a matching entry allocates its index: valid, its own address, its target, and direction 1. Any earlier occupant of that index is overwritten.
- R6: A resolved not-taken control instruction without a matching entry leaves the table unchanged.
- R7: A resolution with res_ctrl=0, or with res_valid=0, changes no entry and gives res_kill=0.
- R8: res_kill is 1 in the resolution cycle exactly when res_valid and res_ctrl are 1 and the actual next PC differs from res_pred_next. The actual next PC is res_target if taken, else res_pc+4.
- R9: When a matching entry mispredicted, its direction bit becomes the actual outcome. Its target becomes res_target when the outcome is taken, and is kept when not taken.
- R10: When a matching entry predicted right, only its direction bit is written (with the outcome). The stored target stays the same even if res_target differs.
- R11: An update is visible at the lookup port in the cycle after the resolution cycle, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| lk_hit | output | 1 | Valid entry with matching full address |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| lk_index | output | IDX_W | Table index used by the lookup |
| res_valid | input | 1 | A resolution is presented this cycle |
| res_ctrl | input | 1 | Resolved instruction is a branch or jump |
| res_pc | input | PC_W | Address of the resolved instruction |
| res_taken | input | 1 | Actual direction |
| res_target | input | PC_W | Actual target when taken |
| res_pred_next | input | PC_W | Next PC fetch used after this instruction |
| res_kill | output | 1 | Mispredict: kill the wrongly fetched path |

## Verification
A corrupted entry shows at the lookup port on the first fetch of any address that maps to its index, one cycle after the resolution that wrote it. It shows as a wrong hit flag or as a next PC that is neither the stored target nor PC+4. A wrong action choice can leave the table looking correct. It is exposed later: a kept target is detected only on a later fetch of the same address after a correct-looking taken resolution, and a missed allocation is detected only on the next fetch of that branch. Because the bench tracks every entry and fetches from a small pool of aliasing addresses, such faults reach a check within a few cycles.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int unsigned INSN_BYTES = 4;

    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_SKIP  = 3'd1,
        ACT_ALLOC = 3'd2,
        ACT_FIX   = 3'd3,
        ACT_TRAIN = 3'd4
    } btb_act_e;
endpackage

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
    import btb_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic             res_valid,
    input  logic             res_ctrl,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_taken,
    input  logic [PC_W-1:0]  res_target,
    input  logic [PC_W-1:0]  res_pred_next,
    input  logic             ent_valid,
    input  logic [PC_W-1:0]  ent_tag,
    output btb_act_e         act,
    output logic             kill
);
    logic             ctrl_ok;
    logic             tag_match;
    logic [PC_W-1:0]  actual_next;
    logic             wrong;

    always_comb begin
        ctrl_ok     = res_valid && res_ctrl;
        tag_match   = ent_valid && (ent_tag == res_pc);
        actual_next = res_taken ? res_target : res_pc + PC_W'(INSN_BYTES);
        wrong       = (actual_next != res_pred_next);
    end

    always_comb begin
        act = ACT_IDLE;
        if (ctrl_ok) begin
            unique case (tag_match)
                1'b0: act = res_taken ? ACT_ALLOC : ACT_SKIP;
                1'b1: act = wrong ? ACT_FIX : ACT_TRAIN;
            endcase
        end
    end

    assign kill = ctrl_ok && wrong;
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PC_W-1:0]   rd_tag,
    output logic [PC_W-1:0]   rd_target,
    output logic              rd_pred,
    input  logic [IDX_W-1:0]  up_idx,
    output logic              up_valid,
    output logic [PC_W-1:0]   up_tag,
    input  btb_act_e          act,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [PC_W-1:0]   wr_target,
    input  logic              wr_taken
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic             valid_q  [DEPTH];
    logic [PC_W-1:0]  tag_q    [DEPTH];
    logic [PC_W-1:0]  target_q [DEPTH];
    logic             pred_q   [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic sel;
        assign sel = (up_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[e]  <= 1'b0;
                tag_q[e]    <= '0;
                target_q[e] <= '0;
                pred_q[e]   <= 1'b0;
            end else if (sel) begin
                unique case (act)
                    ACT_ALLOC: begin
                        valid_q[e]  <= 1'b1;
                        tag_q[e]    <= wr_pc;
                        target_q[e] <= wr_target;
                        pred_q[e]   <= 1'b1;
                    end
                    ACT_FIX: begin
                        pred_q[e] <= wr_taken;
                        if (wr_taken) target_q[e] <= wr_target;
                    end
                    ACT_TRAIN: pred_q[e] <= wr_taken;
                    ACT_IDLE, ACT_SKIP: ;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_valid  = valid_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_target = target_q[rd_idx];
        rd_pred   = pred_q[rd_idx];
        up_valid  = valid_q[up_idx];
        up_tag    = tag_q[up_idx];
    end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             ent_valid,
    input  logic [PC_W-1:0]  ent_tag,
    input  logic [PC_W-1:0]  ent_target,
    input  logic             ent_pred,
    output logic             hit,
    output logic [PC_W-1:0]  next_pc
);
    always_comb begin
        hit     = ent_valid && (ent_tag == fetch_pc);
        next_pc = (hit && ent_pred) ? ent_target
                                    : fetch_pc + PC_W'(INSN_BYTES);
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              lk_hit,
    output logic [PC_W-1:0]   lk_next_pc,
    output logic [IDX_W-1:0]  lk_index,
    input  logic              res_valid,
    input  logic              res_ctrl,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic [PC_W-1:0]   res_target,
    input  logic [PC_W-1:0]   res_pred_next,
    output logic              res_kill
);
    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

    logic [IDX_W-1:0] up_idx;
    logic             rd_valid, rd_pred, up_valid;
    logic [PC_W-1:0]  rd_tag, rd_target, up_tag;
    btb_act_e         act;

    assign lk_index = fetch_pc[IDX_MSB:IDX_LSB];
    assign up_idx   = res_pc[IDX_MSB:IDX_LSB];

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_index),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .rd_pred   (rd_pred),
        .up_idx    (up_idx),
        .up_valid  (up_valid),
        .up_tag    (up_tag),
        .act       (act),
        .wr_pc     (res_pc),
        .wr_target (res_target),
        .wr_taken  (res_taken)
    );

    btb_lookup #(.PC_W(PC_W)) u_lookup (
        .fetch_pc   (fetch_pc),
        .ent_valid  (rd_valid),
        .ent_tag    (rd_tag),
        .ent_target (rd_target),
        .ent_pred   (rd_pred),
        .hit        (lk_hit),
        .next_pc    (lk_next_pc)
    );

    btb_update_ctl #(.PC_W(PC_W)) u_ctl (
        .res_valid     (res_valid),
        .res_ctrl      (res_ctrl),
        .res_pc        (res_pc),
        .res_taken     (res_taken),
        .res_target    (res_target),
        .res_pred_next (res_pred_next),
        .ent_valid     (up_valid),
        .ent_tag       (up_tag),
        .act           (act),
        .kill          (res_kill)
    );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   fetch_pc,
    input logic              lk_hit,
    input logic [PC_W-1:0]   lk_next_pc,
    input logic [IDX_W-1:0]  lk_index,
    input logic              res_valid,
    input logic              res_ctrl,
    input logic [PC_W-1:0]   res_pc,
    input logic              res_taken,
    input logic [PC_W-1:0]   res_target,
    input logic [PC_W-1:0]   res_pred_next,
    input logic              res_kill
);
    AST_MISS_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_next_pc == fetch_pc + PC_W'(4)); // R2

    AST_KILL_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        res_kill |-> (res_valid && res_ctrl)); // R8

    AST_TAKEN_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ctrl && res_taken && res_kill)
        |=> (fetch_pc != $past(res_pc)) || (lk_hit && lk_next_pc == $past(res_target))); // R11

    AST_NOTTAKEN_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ctrl && !res_taken)
        |=> (fetch_pc != $past(res_pc)) || (lk_next_pc == fetch_pc + PC_W'(4))); // R9

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_ctrl)
        |=> (fetch_pc != $past(fetch_pc))
            || (lk_hit == $past(lk_hit) && lk_next_pc == $past(lk_next_pc))); // R7
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_btb_checker (.*);

// File: tb/test_btb_predictor.sv
module test_btb_predictor;
    localparam int unsigned PC_W  = 32;
    localparam int unsigned IDX_W = 4;
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  fetch_pc = '0;
    logic             lk_hit;
    logic [PC_W-1:0]  lk_next_pc;
    logic [IDX_W-1:0] lk_index;
    logic             res_valid = 1'b0, res_ctrl = 1'b0, res_taken = 1'b0;
    logic [PC_W-1:0]  res_pc = '0, res_target = '0, res_pred_next = '0;
    logic             res_kill;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic             m_v   [DEPTH];
    logic [PC_W-1:0]  m_tag [DEPTH];
    logic [PC_W-1:0]  m_tgt [DEPTH];
    logic             m_pred[DEPTH];

    always #5 clk = ~clk;

    btb_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) i_btb_predictor (.*);

    task automatic check(input bit ok, input string tag, input string field,
                         input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s/%s actual=%h expected=%h", tag, field, act, exp);
        end
    endtask

    function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
        return pc[IDX_W+1:2];
    endfunction

    function automatic logic [PC_W-1:0] model_next(input logic [PC_W-1:0] pc);
        logic [IDX_W-1:0] i = idx_of(pc);
        if (m_v[i] && m_tag[i] == pc && m_pred[i]) return m_tgt[i];
        return pc + 4;
    endfunction

    task automatic step(input logic [PC_W-1:0] f, input logic rv, input logic rc,
                        input logic [PC_W-1:0] rp, input logic rt,
                        input logic [PC_W-1:0] rg, input logic [PC_W-1:0] rn,
                        input string tag);
        logic [IDX_W-1:0] fi, ri;
        logic e_hit, e_kill, match;
        @(negedge clk);
        fetch_pc = f; res_valid = rv; res_ctrl = rc; res_pc = rp;
        res_taken = rt; res_target = rg; res_pred_next = rn;
        #1;
        fi = idx_of(f);
        e_hit  = m_v[fi] && (m_tag[fi] == f);
        e_kill = rv && rc && ((rt ? rg : rp + 4) != rn);
        check(lk_hit == e_hit, tag, "R2 hit", 32'(lk_hit), 32'(e_hit));
        check(lk_next_pc == model_next(f), tag, "R3 next", lk_next_pc, model_next(f));
        check(lk_index == fi, tag, "R4 index", 32'(lk_index), 32'(fi));
        check(res_kill == e_kill, tag, "R8 kill", 32'(res_kill), 32'(e_kill));
        @(posedge clk);
        if (rv && rc) begin
            ri = idx_of(rp);
            match = m_v[ri] && (m_tag[ri] == rp);
            if (!match) begin
                if (rt) begin
                    m_v[ri] = 1'b1; m_tag[ri] = rp; m_tgt[ri] = rg; m_pred[ri] = 1'b1;
                end
            end else begin
                if (e_kill && rt) m_tgt[ri] = rg;
                m_pred[ri] = rt;
            end
        end
    endtask

    task automatic peek(input logic [PC_W-1:0] f, input string tag);
        step(f, 1'b0, 1'b0, '0, 1'b0, '0, '0, tag);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end

    localparam logic [PC_W-1:0] A = 32'h0000_1008;
    localparam logic [PC_W-1:0] B = 32'h0000_1010;
    localparam logic [PC_W-1:0] C = 32'h0000_5008; // same index as A

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_pred[i] = 1'b0;
        end
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < 4; i++) peek(32'h100 + 32'(i * 4), "R1 reset");

        step(A, 1, 1, A, 1, 32'h2000, A + 4, "R5 alloc");
        peek(A, "R11 visible");
        peek(C, "R2 alias");
        step(B, 1, 1, B, 0, 32'h9000, B + 4, "R6 nt-miss");
        peek(B, "R6 no-alloc");
        step(B, 1, 0, B, 1, 32'h7000, B + 4, "R7 non-ctrl");
        peek(B, "R7 ignored");
        step(A, 1, 1, A, 0, 32'h2000, 32'h2000, "R9 mispredict");
        peek(A, "R9 dir");
        step(A, 1, 1, A, 0, 32'h2000, A + 4, "R10 train");
        peek(A, "R10 dir");
        step(A, 1, 1, A, 1, 32'h3000, A + 4, "R9 retarget");
        peek(A, "R9 target");
        step(A, 1, 1, A, 1, 32'h4444, 32'h4444, "R10 correct");
        peek(A, "R10 target-kept");
        step(C, 1, 1, C, 1, 32'h6000, C + 4, "R5 overwrite");
        peek(A, "R5 evicted");
        peek(C, "R5 new");

        for (int n = 0; n < 4000; n++) begin
            logic [PC_W-1:0] f, rp, rg, rn;
            logic rv, rc, rt;
            f  = {18'd0, 2'($urandom % 3), 6'd0, 4'($urandom), 2'b00};
            rp = {18'd0, 2'($urandom % 3), 6'd0, 4'($urandom), 2'b00};
            rv = 1'($urandom);
            rc = ($urandom % 5) != 0;
            rt = 1'($urandom);
            rg = {16'd0, 14'($urandom), 2'b00};
            case ($urandom % 4)
                0, 1: rn = model_next(rp);
                2:    rn = rp + 4;
                default: rn = rg;
            endcase
            step(f, rv, rc, rp, rt, rg, rn, "rand");
        end

        done = 1;
        report();
    end
endmodule